// File: doc/BRIEF.md
# DMA Read Prefetch Buffer

This block holds read data fetched from memory on behalf of a bus master until the bus side takes it. It has sixteen longword slots, arranged as two cache lines of eight longwords. Each slot has its own valid flag. The memory side writes any slot by index, and that write marks the slot valid.

The bus side reads the slots strictly in ascending order through a ready/valid port. Because validity is tracked per longword, the bus side can start unloading a line before the whole line has arrived. The unload position stalls on any slot that is not yet valid.

A flush input discards everything the buffer holds and returns the unload position to the first slot. Issuing memory requests and translating addresses are handled elsewhere.

Top module: `rdbuf_top`

## Requirements
- R1: After reset every slot is invalid, `outValid` is 0 and the unload position is slot 0.
- R2: A fill (`fillEn`=1) writes `fillData` into slot `fillIdx` and marks that slot valid. When the unload position points at that slot, `outValid`=1 and `outData` equals the written data from the next clock edge on.
- R3: Slots are presented in ascending index order, one slot per clock cycle in which `outValid` and `outReady` are both 1.
- R4: While the slot at the unload position is invalid, `outValid` is 0 and the position holds, even if later slots are valid. Asserting `outReady` in that state has no effect.
- R5: Unloading a slot clears its valid flag. Once the position comes back round to that slot, it is not presented again unless it has been refilled.
- R6: After slot 15 (the last longword of the second line), the unload position wraps to slot 0.
- R7: A flush clears every valid flag and sets the unload position to 0 at the next edge. A fill in the same cycle as a flush is discarded.
- R8: When a fill targets the slot being unloaded in the same cycle, the fill wins: the slot stays valid and holds the new data.
- R9: While `outReady` is 0, `outValid`, `outData` and the unload position stay unchanged, unless a fill or flush changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillEn | input | 1 | Fill strobe from the memory side |
| fillIdx | input | 4 | Slot index for the fill (bit 3 selects the line) |
| fillData | input | 32 | Longword to store |
| flush | input | 1 | Discard all contents and rewind |
| outValid | output | 1 | Slot at the unload position is valid |
| outReady | input | 1 | Bus side accepts the presented longword |
| outData | output | 32 | Longword at the unload position |

## Verification
Both outputs are decoded directly from registered state. A fill takes effect at the next rising edge and is visible on `outValid` and `outData` right after that edge. An accepted handshake moves the unload position at that same edge, and a flush empties the buffer at its edge. The bench therefore checks the outputs at each falling edge against a model that it advanced, at the preceding rising edge, using the inputs it had applied. It drives new inputs only after that check, so every expected value refers to exactly one edge of history.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
  parameter int WORD_W     = 32;
  parameter int LINE_WORDS = 8;
  parameter int LINES      = 2;
  localparam int DEPTH     = LINE_WORDS * LINES;
  localparam int IDX_W     = $clog2(DEPTH);

  // Strobes from control to datapath
  typedef struct packed {
    logic             setEn;
    logic [IDX_W-1:0] setIdx;
    logic             popEn;
    logic [IDX_W-1:0] popIdx;
    logic             flushEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/rdbuf_datapath.sv
module rdbuf_datapath
  import rdbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] fillData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DEPTH-1:0]  validVec,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.setEn) mem[strobes.setIdx] <= fillData;
  end

  assign rdData = mem[rdIdx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || strobes.flushEn)
        validVec[i] <= 1'b0;
      else if (strobes.setEn && strobes.setIdx == IDX_W'(i))
        validVec[i] <= 1'b1;
      else if (strobes.popEn && strobes.popIdx == IDX_W'(i))
        validVec[i] <= 1'b0;
    end
  end

  // A fill always leaves its slot valid, even against a same-slot pop
  assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.setEn && !strobes.flushEn) |=> validVec[$past(strobes.setIdx)]);

  assert_pop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.popEn && !strobes.flushEn &&
     !(strobes.setEn && strobes.setIdx == strobes.popIdx))
    |=> !validVec[$past(strobes.popIdx)]);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flushEn |=> (validVec == '0));
endmodule

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl
  import rdbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillEn,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             flush,
  input  logic             outReady,
  input  logic [DEPTH-1:0] validVec,
  output logic             outValid,
  output logic [IDX_W-1:0] rdIdx,
  output ctrlStrobes_t     strobes
);
  logic [IDX_W-1:0] rdPtr;
  logic             handshake;

  assign outValid  = validVec[rdPtr];
  assign handshake = outValid && outReady;
  assign rdIdx     = rdPtr;

  always_comb begin
    strobes.setEn   = fillEn && !flush;
    strobes.setIdx  = fillIdx;
    strobes.popEn   = handshake && !flush;
    strobes.popIdx  = rdPtr;
    strobes.flushEn = flush;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      rdPtr <= '0;
    else if (handshake)
      rdPtr <= (rdPtr == IDX_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
  end

  assert_hold_without_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!handshake && !flush) |=> (rdPtr == $past(rdPtr)));

  assert_step_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !flush && rdPtr != IDX_W'(DEPTH - 1))
    |=> (rdPtr == $past(rdPtr) + 1'b1));

  assert_wrap_to_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !flush && rdPtr == IDX_W'(DEPTH - 1)) |=> (rdPtr == '0));

  assert_flush_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rdPtr == '0));
endmodule

// File: rtl/rdbuf_top.sv
module rdbuf_top
  import rdbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [WORD_W-1:0] fillData,
  input  logic              flush,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData
);
  ctrlStrobes_t     strobes;
  logic [DEPTH-1:0] validVec;
  logic [IDX_W-1:0] rdIdx;

  rdbuf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fillEn(fillEn), .fillIdx(fillIdx),
    .flush(flush), .outReady(outReady), .validVec(validVec),
    .outValid(outValid), .rdIdx(rdIdx), .strobes(strobes)
  );

  rdbuf_datapath u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .fillData(fillData),
    .rdIdx(rdIdx), .validVec(validVec), .rdData(outData)
  );
endmodule

// File: tb/rdbuf_top_tb.sv
module rdbuf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fillEn;
  logic [3:0]  fillIdx;
  logic [31:0] fillData;
  logic        flush;
  logic        outValid;
  logic        outReady;
  logic [31:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        mValid [16];
  logic [31:0] mData  [16];
  logic [3:0]  mPtr;

  always #5 clk = ~clk;

  rdbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .fillEn(fillEn), .fillIdx(fillIdx),
    .fillData(fillData), .flush(flush), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  function automatic logic expValid();
    return mValid[mPtr];
  endfunction

  function automatic logic [31:0] expData();
    return mData[mPtr];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    mPtr = '0;
  endtask

  // Check outputs on the falling edge, apply inputs, then advance the model at the rising edge
  task automatic step(input string tag, input logic fe, input logic [3:0] fi,
                      input logic [31:0] fd, input logic rdy, input logic fl);
    logic hs;
    @(negedge clk);
    check(tag, {31'b0, outValid}, {31'b0, expValid()});
    if (expValid()) check(tag, outData, expData());
    fillEn = fe; fillIdx = fi; fillData = fd; outReady = rdy; flush = fl;
    hs = expValid() && rdy;
    @(posedge clk);
    if (fl) model_reset();
    else begin
      if (hs) begin mValid[mPtr] = 1'b0; mPtr = mPtr + 1'b1; end
      if (fe) begin mValid[fi] = 1'b1; mData[fi] = fd; end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; fillEn = 0; fillIdx = 0; fillData = 0; outReady = 0; flush = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: empty after reset, ready has no effect
    step("R1", 0, 0, 0, 1, 0);
    step("R1", 0, 0, 0, 1, 0);
    // R4: later slots valid, slot 0 not: stall
    step("R4", 1, 4'd2, 32'hAAAA0002, 1, 0);
    step("R4", 1, 4'd1, 32'hAAAA0001, 1, 0);
    step("R4", 0, 0, 0, 1, 0);
    // R2: fill slot 0, visible next edge; R9 hold with ready low
    step("R2", 1, 4'd0, 32'hAAAA0000, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0);
    // R3: drain 0,1,2 in order then stall at 3
    step("R3", 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 1, 0);
    step("R4", 0, 0, 0, 1, 0);
    // R8: fill slot 3, then refill same slot while it is popped
    step("R8", 1, 4'd3, 32'h33333333, 0, 0);
    step("R8", 1, 4'd3, 32'h3333BEEF, 1, 0);
    step("R8", 0, 0, 0, 0, 0);
    check("R8", {28'b0, mPtr}, 32'd4);
    // R7: flush with a simultaneous fill
    step("R7", 1, 4'd0, 32'hDEAD0000, 0, 1);
    step("R7", 0, 0, 0, 1, 0);
    check("R7", {28'b0, mPtr}, 32'd0);
    // R6: fill both lines, drain through the wrap
    for (int i = 0; i < 16; i++) step("R2", 1, 4'(i), 32'h5000_0000 + 32'(i), 0, 0);
    for (int i = 0; i < 16; i++) step("R6", 0, 0, 0, 1, 0);
    // R5: after wrap, slot 0 no longer valid
    step("R5", 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 1, 0);
    check("R6", {28'b0, mPtr}, 32'd0);
    // R3: random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic fe, rdy, fl;
      fe  = ($urandom % 3) != 0;
      rdy = ($urandom % 4) != 0;
      fl  = ($urandom % 97) == 0;
      step("R3", fe, 4'($urandom), $urandom, rdy, fl);
    end
    step("R3", 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule